// File: doc/BRIEF.md
# Embedded Video Code Extractor

This block sits on an 8-bit digitized video stream in which the sample bytes and in-band timing codes share the same wires. Every accepted byte is classified in the cycle it arrives. A timing code is the three-byte lead-in 0xFF, 0x00, 0x00 followed by one status byte. The block recognises which codes mark a new line and which mark a new frame, and it follows whether the stream is inside active video. Each cycle it decides whether the byte is written into an attached synchronous SRAM buffer.

Only two kinds of byte are written: the status byte of every start-of-active-video code, and the video samples that lie between such a code and the next end code. Lead-in bytes, end codes and blanking bytes are dropped. A write-address counter advances once per write, so writes pack densely into the buffer even when the input has gaps. A frame-start code moves the counter back to address zero before that code is stored. When the last buffer slot has been written, a sticky full flag blocks every further write until it is cleared.

Top module: `vid_code_extract`

## Requirements
- R1: After reset, sram_we_o, frame_start_o, line_start_o, active_o and buf_full_o are all 0.
- R2: A status byte that follows 0xFF, 0x00, 0x00 is a code. The code is a start code when status bit 4 is 0 and an end code when bit 4 is 1. A start code pulses line_start_o for one cycle. A start code that also has status bit 6 at 1 additionally pulses frame_start_o.
- R3: active_o goes to 1 after a start code and to 0 after an end code. Other bytes leave it unchanged.
- R4: A plain byte is written only while active_o is 1. Plain bytes received outside active video are discarded.
- R5: The status byte of a start code is written. The status byte of an end code is not written. A 0xFF byte is never written, whatever state the block is in.
- R6: The write address increases by one for each write, wrapping from DEPTH-1 to 0. It holds across idle cycles and discarded bytes.
- R7: A frame-start code resets the address counter to 0, and that code's status byte is written at address 0.
- R8: Writing address DEPTH-1 sets buf_full_o. While buf_full_o is 1, nothing is written. A full_clr_i pulse clears the flag, and the next write goes to address 0.
- R9: An incomplete lead-in is abandoned. The 0xFF is dropped, a matching 0x00 is dropped, and the first byte that does not match is handled as a plain byte.
- R10: The write for a byte accepted at a clock edge is presented on the SRAM port, with its address and data, in the following cycle. A cycle with vid_valid_i at 0 produces no write and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vid_byte_i | input | 8 | Incoming video or code byte |
| vid_valid_i | input | 1 | vid_byte_i holds a byte this cycle |
| full_clr_i | input | 1 | Clears the buffer-full flag |
| sram_addr_o | output | AW | SRAM write address (AW = clog2 of DEPTH) |
| sram_data_o | output | 8 | SRAM write data |
| sram_we_o | output | 1 | SRAM write enable |
| frame_start_o | output | 1 | One-cycle pulse on a frame-start code |
| line_start_o | output | 1 | One-cycle pulse on any start code |
| active_o | output | 1 | Stream is inside active video |
| buf_full_o | output | 1 | Buffer full, writes blocked |

## Verification
The bench builds the block with DEPTH set to 16, so the address counter spans four bits. A handful of short lines is then enough to reach the last slot, raise the full flag and wrap the address back to zero. The random stream also scatters 0xFF and 0x00 bytes inside the lines, which exercises abandoned lead-ins both inside and outside active video, and it mixes frame marks into the codes. Directed sequences cover a frame start that arrives while the buffer is full, and the address that follows a clear.

// File: rtl/vce_pkg.sv
package vce_pkg;
  localparam int BYTE_W      = 8;
  localparam int STAT_FRAME  = 6;   // status bit: frame mark
  localparam int STAT_END    = 4;   // status bit: 1 = end code, 0 = start code
  localparam logic [BYTE_W-1:0] LEAD_BYTE = 8'hFF;
  localparam logic [BYTE_W-1:0] ZERO_BYTE = 8'h00;

  typedef enum logic [1:0] {
    SCAN    = 2'd0,
    SEEN_FF = 2'd1,
    SEEN_Z1 = 2'd2,
    SEEN_Z2 = 2'd3
  } lead_state_e;

  function automatic logic is_end_code(input logic [BYTE_W-1:0] status);
    return status[STAT_END];
  endfunction

  function automatic logic is_frame_mark(input logic [BYTE_W-1:0] status);
    return status[STAT_FRAME];
  endfunction
endpackage

// File: rtl/vce_lead_detect.sv
module vce_lead_detect
  import vce_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              valid_i,
  output logic              code_hit_o,
  output logic              plain_o
);
  lead_state_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    code_hit_o = 1'b0;
    plain_o    = 1'b0;
    if (valid_i) begin
      if (st_q == SEEN_Z2) begin
        code_hit_o = 1'b1;
        st_d       = SCAN;
      end else if (byte_i == LEAD_BYTE) begin
        st_d = SEEN_FF;
      end else if (st_q == SEEN_FF && byte_i == ZERO_BYTE) begin
        st_d = SEEN_Z1;
      end else if (st_q == SEEN_Z1 && byte_i == ZERO_BYTE) begin
        st_d = SEEN_Z2;
      end else begin
        plain_o = 1'b1;
        st_d    = SCAN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SCAN;
    else        st_q <= st_d;
  end

  // A lead byte outside a status slot is never classed as plain (R9)
  p_lead_not_plain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && byte_i == LEAD_BYTE && !code_hit_o) |-> !plain_o);

  p_hit_plain_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(code_hit_o && plain_o));
endmodule

// File: rtl/vce_line_track.sv
module vce_line_track
  import vce_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              valid_i,
  input  logic              code_hit_i,
  input  logic              plain_i,
  output logic              active_o,
  output logic              want_wr_o,
  output logic              sol_evt_o,
  output logic              sof_evt_o
);
  logic active_q;

  always_comb begin
    sol_evt_o = valid_i && code_hit_i && !is_end_code(byte_i);
    sof_evt_o = sol_evt_o && is_frame_mark(byte_i);
    want_wr_o = sol_evt_o || (valid_i && plain_i && active_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    active_q <= 1'b0;
    else if (valid_i && code_hit_i) active_q <= !is_end_code(byte_i);
  end

  assign active_o = active_q;

  // Blanking bytes are never requested for writing (R4)
  p_blank_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_i && !active_q) |-> !want_wr_o);

  // End codes leave the active region on the next cycle (R3)
  p_end_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && code_hit_i && is_end_code(byte_i)) |=> !active_o);
endmodule

// File: rtl/vce_addr_ctr.sv
module vce_addr_ctr #(
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          want_wr_i,
  input  logic          sof_evt_i,
  input  logic          clr_full_i,
  output logic          wr_go_o,
  output logic [AW-1:0] slot_o,
  output logic          full_o
);
  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] step_slot(input logic [AW-1:0] a);
    return (a == LAST_SLOT) ? '0 : a + 1'b1;
  endfunction

  logic [AW-1:0] cnt_q;
  logic          full_q;

  assign slot_o  = sof_evt_i ? '0 : cnt_q;
  assign wr_go_o = want_wr_i && !full_q;
  assign full_o  = full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      if (wr_go_o)        cnt_q <= step_slot(slot_o);
      else if (sof_evt_i) cnt_q <= '0;
      if (wr_go_o && slot_o == LAST_SLOT) full_q <= 1'b1;
      else if (clr_full_i)                full_q <= 1'b0;
    end
  end

  // Frame start stores its code at slot zero (R7)
  p_sof_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go_o && sof_evt_i) |-> slot_o == '0);

  // Full blocks every write (R8)
  p_full_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !wr_go_o);
endmodule

// File: rtl/vid_code_extract.sv
module vid_code_extract
  import vce_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    vid_byte_i,
  input  logic          vid_valid_i,
  input  logic          full_clr_i,
  output logic [AW-1:0] sram_addr_o,
  output logic [7:0]    sram_data_o,
  output logic          sram_we_o,
  output logic          frame_start_o,
  output logic          line_start_o,
  output logic          active_o,
  output logic          buf_full_o
);
  logic          code_hit, plain;
  logic          want_wr, sol_evt, sof_evt;
  logic          wr_go;
  logic [AW-1:0] slot;

  vce_lead_detect u_det (
    .clk(clk), .rst_n(rst_n), .byte_i(vid_byte_i), .valid_i(vid_valid_i),
    .code_hit_o(code_hit), .plain_o(plain)
  );

  vce_line_track u_trk (
    .clk(clk), .rst_n(rst_n), .byte_i(vid_byte_i), .valid_i(vid_valid_i),
    .code_hit_i(code_hit), .plain_i(plain), .active_o(active_o),
    .want_wr_o(want_wr), .sol_evt_o(sol_evt), .sof_evt_o(sof_evt)
  );

  vce_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk(clk), .rst_n(rst_n), .want_wr_i(want_wr), .sof_evt_i(sof_evt),
    .clr_full_i(full_clr_i), .wr_go_o(wr_go), .slot_o(slot),
    .full_o(buf_full_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_we_o     <= 1'b0;
      sram_addr_o   <= '0;
      sram_data_o   <= '0;
      frame_start_o <= 1'b0;
      line_start_o  <= 1'b0;
    end else begin
      sram_we_o     <= wr_go;
      frame_start_o <= sof_evt;
      line_start_o  <= sol_evt;
      if (wr_go) begin
        sram_addr_o <= slot;
        sram_data_o <= vid_byte_i;
      end
    end
  end

  // Checker-side record of the last written address (R6)
  logic          seen_wr_q;
  logic [AW-1:0] last_addr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_wr_q   <= 1'b0;
      last_addr_q <= '0;
    end else if (sram_we_o) begin
      seen_wr_q   <= 1'b1;
      last_addr_q <= sram_addr_o;
    end
  end

  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_we_o && !frame_start_o && seen_wr_q) |->
      sram_addr_o == ((last_addr_q == AW'(DEPTH - 1)) ? '0 : last_addr_q + 1'b1));

  p_full_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full_o |=> !sram_we_o);

  p_no_lead_written_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sram_we_o && sram_data_o == LEAD_BYTE));

  p_sof_with_sol_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> line_start_o);

  p_sol_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    line_start_o |-> active_o);
endmodule

// File: tb/vid_code_extract_bench.sv
module vid_code_extract_bench;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    vbyte = '0;
  logic          vvalid = 1'b0;
  logic          fclr = 1'b0;
  logic [AW-1:0] addr;
  logic [7:0]    data;
  logic          we, sof, sol, act, full;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state
  int  m_st = 0;
  bit  m_act = 0;
  int  m_cnt = 0;
  bit  m_full = 0;
  bit  e_we, e_sof, e_sol;
  int  e_addr;
  logic [7:0] e_data;

  always #5 clk = ~clk;

  vid_code_extract #(.DEPTH(DEPTH)) u_vid_code_extract (
    .clk(clk), .rst_n(rst_n), .vid_byte_i(vbyte), .vid_valid_i(vvalid),
    .full_clr_i(fclr), .sram_addr_o(addr), .sram_data_o(data),
    .sram_we_o(we), .frame_start_o(sof), .line_start_o(sol),
    .active_o(act), .buf_full_o(full)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // reference model: expected outcome of one input cycle
  function automatic void model(input logic [7:0] b, input bit v);
    bit is_code = 0, is_plain = 0, start_code;
    e_we = 0; e_sof = 0; e_sol = 0; e_addr = 0; e_data = b;
    if (!v) return;
    if (m_st == 3) begin is_code = 1; m_st = 0; end
    else if (b == 8'hFF) m_st = 1;
    else if (b == 8'h00 && (m_st == 1 || m_st == 2)) m_st = m_st + 1;
    else begin is_plain = 1; m_st = 0; end
    start_code = is_code && (b[4] == 1'b0);
    e_sol = start_code;
    e_sof = start_code && b[6];
    if (e_sof) m_cnt = 0;
    if ((start_code || (is_plain && m_act)) && !m_full) begin
      e_we = 1;
      e_addr = m_cnt;
      if (m_cnt == DEPTH - 1) m_full = 1;
      m_cnt = (m_cnt + 1) % DEPTH;
    end
    if (is_code) m_act = !b[4];
  endfunction

  task automatic send(input logic [7:0] b, input bit v, input string wtag);
    @(negedge clk);
    vbyte = b; vvalid = v;
    model(b, v);
    @(negedge clk);
    vvalid = 1'b0;
    chk(wtag, we, e_we);
    if (e_we) begin
      chk("R6 addr", addr, e_addr);
      chk("R5 data", data, e_data);
    end
    chk("R2 line", sol, e_sol);
    chk("R2 frame", sof, e_sof);
    chk("R3 active", act, m_act);
    chk("R8 full", full, m_full);
  endtask

  task automatic code(input logic [7:0] st, input string wtag);
    send(8'hFF, 1, "R5 lead"); send(8'h00, 1, "R5 lead");
    send(8'h00, 1, "R5 lead"); send(st, 1, wtag);
  endtask

  task automatic clear_full();
    @(negedge clk); fclr = 1'b1; model(8'h00, 0);
    m_full = 0;
    @(negedge clk); fclr = 1'b0;
    chk("R8 clear", full, 0);
    chk("R10 idle", we, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 we", we, 0); chk("R1 sof", sof, 0); chk("R1 sol", sol, 0);
    chk("R1 active", act, 0); chk("R1 full", full, 0);
    rst_n = 1'b1;

    // blanking bytes discarded, then a frame start code at address 0
    send(8'h10, 1, "R4 blank");
    send(8'h80, 1, "R4 blank");
    code(8'hC0, "R7 frame code");
    send(8'h55, 1, "R4 sample");
    send(8'h66, 0, "R10 no valid");
    send(8'h77, 1, "R6 after gap");
    // abandoned lead-in inside active video
    send(8'hFF, 1, "R9 ff dropped");
    send(8'h12, 1, "R9 plain after ff");
    send(8'hFF, 1, "R9 ff dropped");
    send(8'h00, 1, "R9 zero dropped");
    send(8'h34, 1, "R9 plain after ff00");
    code(8'hD0, "R5 end code");
    send(8'h21, 1, "R4 blank");
    code(8'h80, "R5 line code");

    // fill the buffer, then a frame start while full, then clear
    for (int i = 0; i < DEPTH; i++) send(8'(8'h20 + i), 1, "R8 fill");
    chk("R8 full set", full, 1);
    code(8'hC0, "R8 frame while full");
    clear_full();
    send(8'h42, 1, "R8 after clear");
    chk("R8 base", addr, 0);

    // random lines
    for (int ln = 0; ln < 300; ln++) begin
      logic [7:0] st;
      st = 8'h80 | (($urandom % 6 == 0) ? 8'h40 : 8'h00);
      code(st, "R2 rand start");
      for (int k = 0; k < 1 + int'($urandom % 12); k++) begin
        logic [7:0] b;
        int r;
        r = $urandom % 16;
        b = (r == 0) ? 8'hFF : (r == 1) ? 8'h00 : 8'($urandom);
        send(b, ($urandom % 4) != 0, "R4 rand");
      end
      code(8'h90 | (($urandom % 2 != 0) ? 8'h40 : 8'h00), "R5 rand end");
      for (int k = 0; k < int'($urandom % 4); k++)
        send(8'($urandom % 8'hF0), 1, "R4 rand blank");
      if (m_full && ($urandom % 2 != 0)) clear_full();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule